// File: doc/BRIEF.md
# Event Interrupt Mask and Status Controller

This block gathers six single-cycle hardware event pulses into sticky status flags and raises one interrupt line when any flagged event is enabled and the global enable is on. Software reaches it through a small word-addressed register port: one address shows the status flags, which are cleared by writing ones. Two further addresses give access to the same enable mask. One of them only turns enable bits on and the other only turns them off, so no read-modify-write sequence is ever needed.

The block also counts scheduling-overrun events in a small wrapping counter. It drives a permit output that a list-processing engine must observe before it writes back another completed-descriptor list: while the write-back flag is pending, the permit is withdrawn.

Top module: `irq_event_ctrl`

## Requirements
- R1: After a synchronous active-low reset all status flags, all enable bits and the overrun counter are zero, `irq_o` is low and `wb_permit_o` is high.
- R2: A pulse on event input k (k = 0..5) sets the status flag at bit position 0, 1, 2, 3, 5 or 6 respectively (overrun, write-back done, frame start, resume, frame-number overflow, hub status change), visible at address 0 after the next clock edge.
- R3: Writing address 0 clears every status flag whose data bit is 1; flags written with 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Writing address 1 sets each enable bit whose data bit is 1 (source bits and master bit 31); zero bits leave the mask unchanged.
- R6: Writing address 2 clears each enable bit whose data bit is 1; zero bits leave the mask unchanged.
- R7: Reading address 1 or address 2 returns the enable mask including master bit 31.
- R8: `irq_o` is high exactly when master bit 31 is set and some status flag has its enable bit set.
- R9: While master bit 31 is clear, `irq_o` stays low whatever the flags and source enables hold.
- R10: `wb_permit_o` is the inverse of the write-back status flag (bit 1).
- R11: A 2-bit overrun counter, read at bits 17:16 of address 0, increments on every overrun event (input 0) even when the overrun flag is already set, and wraps from 3 to 0; status writes do not change it.
- R12: Bit positions that hold no flag, enable or count read as zero and ignore writes; address 3 reads zero and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Word address: 0 status, 1 enable-set, 2 enable-clear |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per asserted cycle |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_i | input | 6 | Event pulses, index order as in R2 |
| wb_permit_o | output | 1 | High when a new write-back may be performed |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can collide in one cycle are the hardware setting of a status flag and the software clear of that same flag. The bench drives a write of ones to address 0 in the very cycle that the write-back event pulses, clearing the overrun flag at the same time. It judges the outcome after the edge: the write-back flag must read set, the overrun flag cleared, the permit low and the interrupt still high.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants, address codes and the source-to-bit map
// for the event interrupt controller. Assumes six sources and a 32-bit
// register word; bit 4 of the layout is intentionally left unused.
package irq_ctrl_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_SRC    = 6;
    localparam int ADDR_W     = 2;
    localparam int MASTER_BIT = 31;
    localparam int CNT_W      = 2;
    localparam int CNT_LSB    = 16;
    localparam int OVR_SRC    = 0;
    localparam int WB_SRC     = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    // Bit position of source k in the status and enable words.
    function automatic int src_pos(input int k);
        return (k < 4) ? k : k + 1;
    endfunction

    // Word with a one at every source position.
    function automatic logic [REG_W-1:0] src_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_SRC; k++) m[src_pos(k)] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] EN_VALID = src_mask() | (REG_W'(1) << MASTER_BIT);

endpackage

// File: rtl/irq_status_bank.sv
// Sticky status flags for each event source plus the overrun counter.
// Assumes event pulses and clear strobes are synchronous to clk and that
// clr_i is already qualified by the register write decode.
module irq_status_bank
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int CW    = CNT_W,
    parameter int OVR   = OVR_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [CW-1:0]    ovr_cnt_o
);

    logic [N_SRC-1:0] flag_q;
    logic [CW-1:0]    cnt_q;

    for (genvar k = 0; k < N_SRC; k++) begin : g_flag
        // Set on event, clear on write-one, event taking precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[k] <= 1'b0;
            else if (evt_i[k]) flag_q[k] <= 1'b1;
            else if (clr_i[k]) flag_q[k] <= 1'b0;
        end

        AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> flag_q[k]);                                   // R2
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[k] && !clr_i[k]) |=> flag_q[k]);                   // R3
        AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[k] && clr_i[k]) |=> flag_q[k]);                     // R4
    end

    // Count every overrun pulse regardless of the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (evt_i[OVR]) cnt_q <= cnt_q + 1'b1;
    end

    AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[OVR] |=> cnt_q == CW'($past(cnt_q) + 1'b1));             // R11
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i[OVR] |=> $stable(cnt_q));                               // R11

    assign flag_o    = flag_q;
    assign ovr_cnt_o = cnt_q;

endmodule

// File: rtl/irq_enable_mask.sv
// Enable mask reached through a set port and a clear port.
// Assumes set_i and clr_i are already qualified by the write decode and
// are never both non-zero in one cycle; bits outside VALID never store.
module irq_enable_mask
    import irq_ctrl_pkg::*;
#(
    parameter int               W     = REG_W,
    parameter int               MBIT  = MASTER_BIT,
    parameter logic [W-1:0]     VALID = EN_VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] en_o
);

    logic [W-1:0] en_q;

    // OR in set bits, then knock out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | (set_i & VALID)) & ~clr_i;
    end

    AST_MASTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[MBIT] && !clr_i[MBIT]) |=> en_q[MBIT]);                 // R5
    AST_MASTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[MBIT] |=> !en_q[MBIT]);                                  // R6
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(en_q));               // R5

    assign en_o = en_q;

endmodule

// File: rtl/irq_line_gen.sv
// Combines source flags with their enables and the master bit.
// Assumes flags arrive in source-index order, enables in word layout.
module irq_line_gen
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int W     = REG_W,
    parameter int MBIT  = MASTER_BIT
) (
    input  logic [N_SRC-1:0] flag_i,
    input  logic [W-1:0]     en_i,
    output logic             irq_o
);

    logic [N_SRC-1:0] hit;

    for (genvar k = 0; k < N_SRC; k++) begin : g_hit
        assign hit[k] = flag_i[k] & en_i[src_pos(k)];
    end

    // Master bit gates the OR of enabled flags.
    always_comb irq_o = en_i[MBIT] & (|hit);

endmodule

// File: rtl/irq_event_ctrl.sv
// Top: register decode, read mux, and wiring of the status bank, the
// enable mask and the interrupt line. Assumes one register access per
// cycle, reads combinational, writes taking effect at the next edge.
module irq_event_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                reg_we,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_SRC-1:0]  evt_i,
    output logic                wb_permit_o,
    output logic                irq_o
);

    logic                wr_stat, wr_set, wr_clr;
    logic [NUM_SRC-1:0]  flag_clr;
    logic [NUM_SRC-1:0]  flags;
    logic [CNT_W-1:0]    ovr_cnt;
    logic [REG_W-1:0]    en_set, en_clr, en_mask;
    logic [REG_W-1:0]    stat_word;

    // Decode the write strobe per register.
    always_comb begin
        wr_stat = reg_we && (reg_addr == SEL_STATUS);
        wr_set  = reg_we && (reg_addr == SEL_EN_SET);
        wr_clr  = reg_we && (reg_addr == SEL_EN_CLR);
        en_set  = wr_set ? reg_wdata : '0;
        en_clr  = wr_clr ? reg_wdata : '0;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_map
        assign flag_clr[k] = wr_stat & reg_wdata[src_pos(k)];
    end

    // Assemble the status word from flags and the overrun count.
    always_comb begin
        stat_word = '0;
        for (int k = 0; k < NUM_SRC; k++) stat_word[src_pos(k)] = flags[k];
        stat_word[CNT_LSB +: CNT_W] = ovr_cnt;
    end

    // Select read data by address; spare address reads zero.
    always_comb begin
        unique case (reg_addr)
            SEL_STATUS:             reg_rdata = stat_word;
            SEL_EN_SET, SEL_EN_CLR: reg_rdata = en_mask;
            default:                reg_rdata = '0;
        endcase
    end

    irq_status_bank #(.N_SRC(NUM_SRC), .CW(CNT_W), .OVR(OVR_SRC)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_i     (flag_clr),
        .flag_o    (flags),
        .ovr_cnt_o (ovr_cnt)
    );

    irq_enable_mask #(.W(REG_W), .MBIT(MASTER_BIT), .VALID(EN_VALID)) i_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en_mask)
    );

    irq_line_gen #(.N_SRC(NUM_SRC), .W(REG_W), .MBIT(MASTER_BIT)) i_line (
        .flag_i (flags),
        .en_i   (en_mask),
        .irq_o  (irq_o)
    );

    assign wb_permit_o = ~flags[WB_SRC];

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[MASTER_BIT] |-> !irq_o);                              // R9
    AST_WB_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[WB_SRC] |=> !wb_permit_o);                               // R10
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_stat, wr_set, wr_clr}) <= 1);                   // R12

endmodule

// File: tb/test_irq_event_ctrl.sv
module test_irq_event_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [5:0]  evt_i = '0;
    logic        wb_permit_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_event_ctrl i_irq_event_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .wb_permit_o(wb_permit_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [5:0]  evt;
        logic [1:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic        exp_perm;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b0, 2'd0, 32'h0,        6'b000001, 2'd0, 32'h0001_0001, 1'b0, 1'b1}, // R2 R11
        '{4'd11, 1'b0, 2'd0, 32'h0,        6'b000001, 2'd0, 32'h0002_0001, 1'b0, 1'b1}, // R11 count with flag set
        '{4'd10, 1'b0, 2'd0, 32'h0,        6'b000010, 2'd0, 32'h0002_0003, 1'b0, 1'b0}, // R10
        '{4'd9,  1'b1, 2'd1, 32'h0000_0002, 6'b0,     2'd1, 32'h0000_0002, 1'b0, 1'b0}, // R9 master off
        '{4'd7,  1'b1, 2'd1, 32'h8000_0000, 6'b0,     2'd2, 32'h8000_0002, 1'b1, 1'b0}, // R7 R8
        '{4'd5,  1'b1, 2'd1, 32'h0,        6'b0,      2'd1, 32'h8000_0002, 1'b1, 1'b0}, // R5 zero write
        '{4'd3,  1'b1, 2'd0, 32'h0000_0002, 6'b0,     2'd0, 32'h0002_0001, 1'b0, 1'b1}, // R3
        '{4'd2,  1'b0, 2'd0, 32'h0,        6'b000100, 2'd0, 32'h0002_0005, 1'b0, 1'b1}, // R2
        '{4'd12, 1'b1, 2'd1, 32'hFFFF_FFFF, 6'b0,     2'd1, 32'h8000_006F, 1'b1, 1'b1}, // R12 R5
        '{4'd9,  1'b1, 2'd2, 32'h8000_0000, 6'b0,     2'd2, 32'h0000_006F, 1'b0, 1'b1}, // R9 R6
        '{4'd6,  1'b1, 2'd2, 32'h0,        6'b0,      2'd2, 32'h0000_006F, 1'b0, 1'b1}, // R6 zero write
        '{4'd8,  1'b1, 2'd1, 32'h8000_0000, 6'b0,     2'd1, 32'h8000_006F, 1'b1, 1'b1}, // R8
        '{4'd2,  1'b0, 2'd0, 32'h0,        6'b111000, 2'd0, 32'h0002_006D, 1'b1, 1'b1}, // R2 upper sources
        '{4'd3,  1'b1, 2'd0, 32'hFFFF_FFFF, 6'b0,     2'd0, 32'h0002_0000, 1'b0, 1'b1}, // R3 R11 count kept
        '{4'd11, 1'b0, 2'd0, 32'h0,        6'b000001, 2'd0, 32'h0003_0001, 1'b1, 1'b1}, // R11
        '{4'd11, 1'b0, 2'd0, 32'h0,        6'b000001, 2'd0, 32'h0000_0001, 1'b1, 1'b1}, // R11 wrap
        '{4'd12, 1'b1, 2'd3, 32'hFFFF_FFFF, 6'b0,     2'd3, 32'h0000_0000, 1'b1, 1'b1}, // R12 spare addr
        '{4'd4,  1'b1, 2'd0, 32'h0000_0003, 6'b000010, 2'd0, 32'h0000_0002, 1'b1, 1'b0}, // R4 event beats clear
        '{4'd6,  1'b1, 2'd2, 32'h0000_0002, 6'b0,     2'd2, 32'h8000_006D, 1'b0, 1'b0}  // R6 R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [1:0] a, output logic [31:0] d);
        reg_we = 1'b0; evt_i = '0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic check_reset_state(input string tag);
        logic [31:0] d;
        read_at(2'd0, d); check({tag, " status"}, d, 32'h0);
        read_at(2'd1, d); check({tag, " enables"}, d, 32'h0);
        check({tag, " irq"}, {31'b0, irq_o}, 32'h0);
        check({tag, " permit"}, {31'b0, wb_permit_o}, 32'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 initial");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_we = VEC[i].we; reg_addr = VEC[i].addr;
            reg_wdata = VEC[i].wdata; evt_i = VEC[i].evt;
            @(posedge clk);
            #1 read_at(VEC[i].raddr, d);
            check($sformatf("R%0d vector %0d rdata", VEC[i].req, i), d, VEC[i].exp_rd);
            check($sformatf("R%0d vector %0d irq", VEC[i].req, i), {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
            check($sformatf("R%0d vector %0d permit", VEC[i].req, i), {31'b0, wb_permit_o}, {31'b0, VEC[i].exp_perm});
        end

        // R10: clear write-back flag, permit returns.
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h2;
        @(posedge clk);
        #1 read_at(2'd0, d);
        check("R10 permit after clear", {31'b0, wb_permit_o}, 32'h1);

        // R1: reset in mid-run wipes everything.
        @(negedge clk);
        evt_i = 6'b111111; rst_n = 1'b0;
        @(posedge clk);
        #1 evt_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 mid-run");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule